// File: doc/BRIEF.md
# Interleaved I/Q Parallel Bus Driver

This block sits on the host side of a dual-channel parallel converter that shares one data bus between its two channels. It takes paired in-phase (I) and quadrature (Q) samples through a valid/ready handshake. It derives the converter clock by dividing the system clock. The bus carries the I word around the rising converter-clock edge and the Q word around the falling edge, so each channel captures its own word on its own edge.

Bus transitions happen only at the midpoints between the clock edges. This keeps the setup margin before each capture edge and the hold margin after it as wide as the division allows. When no new pair is offered in a converter period, the last accepted pair is sent again.

A two-bit mode request is turned into the converter's power-down and enable lines. After a run request, streaming is held off for a programmable wake-up time. It then starts on a converter-period boundary, with the active-low chip select falling ahead of the first capture edge. Leaving run mode stops streaming, deselects the converter and parks the bus at zero.

Top module: `iq_bus_driver`

## Requirements
- R1: After reset the outputs are: dac_pd = 1, dac_en = 0, dac_sel_n = 1, dac_data = 0 and smp_ready = 0.
- R2: dac_clk has a period of CLK_DIV system cycles. It is high for CLK_DIV/2 of them, starting from its rising edge.
- R3: The mode request is encoded as 00 = shutdown, 01 = standby, 10 = run and 11 = shutdown. The outputs follow one cycle after the request: shutdown gives dac_pd = 1 and dac_en = 0, standby gives 0 and 0, and run gives 0 and 1. dac_pd and dac_en are never both 1.
- R4: After dac_en rises, smp_ready stays low and dac_sel_n stays high for at least WAKE_CYCLES system cycles. This holds again on every later run request.
- R5: While streaming, smp_ready is high for exactly one system cycle in each converter period.
- R6: A pair accepted on a ready cycle appears with its I word on dac_data at the next rising edge of dac_clk and its Q word at the following falling edge.
- R7: While selected, dac_data changes only at the quarter and three-quarter points of the converter period. This gives at least 10 ns of setup before each dac_clk edge (at the default division and a 4 ns system clock) and at least one system cycle of hold after it.
- R8: In a period where smp_valid is low on the ready cycle, the previous pair is sent again and the values on smp_i and smp_q have no effect.
- R9: dac_sel_n falls at least 5 ns (two system cycles at 4 ns) before the first rising edge of dac_clk that captures streamed data.
- R10: When the mode leaves run, smp_ready drops one cycle after the request. dac_sel_n returns high and dac_data returns to zero two cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 2 | Requested power mode (see R3) |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | The block takes the pair on this cycle |
| smp_i | input | DATA_W | In-phase sample |
| smp_q | input | DATA_W | Quadrature sample |
| dac_clk | output | 1 | Divided converter clock |
| dac_data | output | DATA_W | Shared interleaved data bus |
| dac_sel_n | output | 1 | Active-low converter select |
| dac_pd | output | 1 | Converter power-down line |
| dac_en | output | 1 | Converter enable line |

## Verification
The mode lines are due one system cycle after a request. Deselection and the parked bus are due two cycles after leaving run. The I word is due on the bus one cycle after the ready handshake and is captured at the rising dac_clk edge three cycles later (default division of 12); the Q word is captured six cycles after that, at the falling edge. The bench samples on the falling system-clock edge and detects dac_clk edges from two successive samples. It compares the bus on the sample where an edge is first seen, measures how many samples the value had been stable before that edge, and checks the sample after the edge for hold. Wake-up and chip-select lead are counted in samples from the observed enable and select transitions.

// File: rtl/iqd_pkg.sv
// Shared definitions for the interleaved I/Q bus driver.
package iqd_pkg;

    // Power mode request encoding seen on mode_req.
    typedef enum logic [1:0] {
        MODE_SHUT = 2'b00,
        MODE_STBY = 2'b01,
        MODE_RUN  = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

endpackage

// File: rtl/iqd_clock_gen.sv
// Converter clock generator.
// Divides the system clock by DIV (at least 4) with a free-running phase
// counter. dac clock is high for phase 0..DIV/2-1. Also flags the system
// cycle just before the I slot (three-quarter point) and the Q slot
// (quarter point) so that the bus register updates exactly there.
// Assumes: DIV >= 4.
module iqd_clock_gen #(
    parameter int unsigned DIV = 12,
    localparam int unsigned CW = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] phase_o,
    output logic          conv_clk_o,
    output logic          i_slot_o,
    output logic          q_slot_o
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned QTR  = HALF / 2;
    localparam int unsigned TQ   = HALF + (DIV - HALF) / 2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_next;

    // Next phase value with wrap at DIV-1.
    always_comb begin
        if (cnt_q == CW'(DIV - 1)) cnt_next = '0;
        else                       cnt_next = cnt_q + CW'(1);
    end

    // Phase counter and registered converter clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= CW'(DIV - 1);
            conv_clk_o <= 1'b0;
        end else begin
            cnt_q      <= cnt_next;
            conv_clk_o <= (cnt_next < CW'(HALF));
        end
    end

    // Slot strobes: true on the cycle before the bus must change.
    always_comb begin
        phase_o  = cnt_q;
        i_slot_o = (cnt_q == CW'(TQ - 1));
        q_slot_o = (cnt_q == CW'(QTR - 1));
    end

    AST_RISE_AT_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_clk_o) |-> (cnt_q == '0)); // R2
    AST_FALL_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_clk_o) |-> (cnt_q == CW'(HALF))); // R2

endmodule

// File: rtl/iqd_mode_ctrl.sv
// Power mode sequencer.
// Registers the mode request into the power-down and enable lines and
// counts the wake-up interval after entering run. wake_done_o is high
// once WAKE system cycles have passed with enable asserted.
// Assumes: WAKE >= 1.
module iqd_mode_ctrl #(
    parameter int unsigned WAKE = 20,
    localparam int unsigned WW = $clog2(WAKE + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_req,
    output logic       pd_o,
    output logic       en_o,
    output logic       wake_done_o
);
    import iqd_pkg::*;

    logic [WW-1:0] wcnt_q;

    // Decode the request into the two converter control lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_o <= 1'b1;
            en_o <= 1'b0;
        end else begin
            unique case (mode_req)
                MODE_RUN:  begin pd_o <= 1'b0; en_o <= 1'b1; end
                MODE_STBY: begin pd_o <= 1'b0; en_o <= 1'b0; end
                default:   begin pd_o <= 1'b1; en_o <= 1'b0; end
            endcase
        end
    end

    // Wake-up counter: runs while enabled, saturates at WAKE.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_o)           wcnt_q <= '0;
        else if (wcnt_q != WW'(WAKE))  wcnt_q <= wcnt_q + WW'(1);
    end

    assign wake_done_o = en_o && (wcnt_q == WW'(WAKE));

    AST_PD_EXCLUDES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pd_o |-> !en_o); // R3
    AST_WAKE_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> !wake_done_o); // R4

endmodule

// File: rtl/iqd_lane_mux.sv
// Sample lane multiplexer.
// Holds the last accepted I/Q pair and drives the shared bus: I at the
// three-quarter point, Q at the quarter point of each converter period.
// Streaming starts at an I slot once wake-up is done; the select line
// falls together with the first I word. Without wake_done the converter
// is deselected and the bus is parked at zero.
// Assumes: i_slot and q_slot are single-cycle strobes once per period.
module iqd_lane_mux #(
    parameter int unsigned W   = 10,
    parameter int unsigned DIV = 12,
    localparam int unsigned CW = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] phase,
    input  logic          i_slot,
    input  logic          q_slot,
    input  logic          wake_done,
    input  logic          smp_valid,
    input  logic [W-1:0]  smp_i,
    input  logic [W-1:0]  smp_q,
    output logic          smp_ready,
    output logic [W-1:0]  bus_o,
    output logic          sel_n_o
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned QTR  = HALF / 2;
    localparam int unsigned TQ   = HALF + (DIV - HALF) / 2;

    logic [W-1:0] held_i_q;
    logic [W-1:0] held_q_q;
    logic         stream_q;

    // One ready cycle per converter period once awake.
    assign smp_ready = wake_done && i_slot;

    // Pair hold registers, bus register and select sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_i_q <= '0;
            held_q_q <= '0;
            bus_o    <= '0;
            sel_n_o  <= 1'b1;
            stream_q <= 1'b0;
        end else if (!wake_done) begin
            bus_o    <= '0;
            sel_n_o  <= 1'b1;
            stream_q <= 1'b0;
        end else if (i_slot) begin
            stream_q <= 1'b1;
            sel_n_o  <= 1'b0;
            if (smp_valid) begin
                held_i_q <= smp_i;
                held_q_q <= smp_q;
                bus_o    <= smp_i;
            end else begin
                bus_o    <= held_i_q;
            end
        end else if (q_slot && stream_q) begin
            bus_o <= held_q_q;
        end
    end

    AST_BUS_AT_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n_o && !$stable(bus_o)) |-> (phase == CW'(TQ) || phase == CW'(QTR))); // R7
    AST_PARKED_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_o |-> (bus_o == '0)); // R10
    AST_READY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready); // R5

endmodule

// File: rtl/iq_bus_driver.sv
// Interleaved I/Q parallel bus driver (top).
// Connects the converter clock generator, the power mode sequencer and
// the sample lane multiplexer. All outputs are registered except
// smp_ready, which is a decode of registered state.
// Assumes: CLK_DIV >= 4, WAKE_CYCLES >= 1.
module iq_bus_driver #(
    parameter int unsigned DATA_W      = 10,
    parameter int unsigned CLK_DIV     = 12,
    parameter int unsigned WAKE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_req,
    input  logic              smp_valid,
    output logic              smp_ready,
    input  logic [DATA_W-1:0] smp_i,
    input  logic [DATA_W-1:0] smp_q,
    output logic              dac_clk,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_sel_n,
    output logic              dac_pd,
    output logic              dac_en
);
    localparam int unsigned CW = $clog2(CLK_DIV);

    logic [CW-1:0] phase;
    logic          i_slot;
    logic          q_slot;
    logic          wake_done;

    iqd_clock_gen #(.DIV(CLK_DIV)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_o    (phase),
        .conv_clk_o (dac_clk),
        .i_slot_o   (i_slot),
        .q_slot_o   (q_slot)
    );

    iqd_mode_ctrl #(.WAKE(WAKE_CYCLES)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_req    (mode_req),
        .pd_o        (dac_pd),
        .en_o        (dac_en),
        .wake_done_o (wake_done)
    );

    iqd_lane_mux #(.W(DATA_W), .DIV(CLK_DIV)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .i_slot    (i_slot),
        .q_slot    (q_slot),
        .wake_done (wake_done),
        .smp_valid (smp_valid),
        .smp_i     (smp_i),
        .smp_q     (smp_q),
        .smp_ready (smp_ready),
        .bus_o     (dac_data),
        .sel_n_o   (dac_sel_n)
    );

endmodule

// File: tb/iq_bus_driver_test.sv
// Self-checking bench for iq_bus_driver with default parameters.
module iq_bus_driver_test;
    localparam int W      = 10;
    localparam int DIV    = 12;
    localparam int HALF   = DIV / 2;
    localparam int WAKE   = 20;
    localparam int SETUP  = 3;   // ceil(10 ns / 4 ns)
    localparam int CSLEAD = 2;   // ceil(5 ns / 4 ns)
    localparam int NVEC   = 8;

    // {valid, I, Q}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 10'h155, 10'h2AA},
        {1'b1, 10'h3FF, 10'h000},
        {1'b0, 10'h123, 10'h321},
        {1'b0, 10'h0F0, 10'h00F},
        {1'b1, 10'h000, 10'h3FF},
        {1'b1, 10'h200, 10'h1FF},
        {1'b0, 10'h3FF, 10'h3FF},
        {1'b1, 10'h001, 10'h3FE}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_req = 2'b00;
    logic         smp_valid = 1'b0;
    logic         smp_ready;
    logic [W-1:0] smp_i = '0;
    logic [W-1:0] smp_q = '0;
    logic         dac_clk;
    logic [W-1:0] dac_data;
    logic         dac_sel_n;
    logic         dac_pd;
    logic         dac_en;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic         clk_prev = 1'b0;
    logic [W-1:0] bus_prev = '0;
    int           age = 0;
    bit           rose = 1'b0;
    bit           fell = 1'b0;

    always #2 clk = ~clk;

    iq_bus_driver uut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req),
        .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_i(smp_i), .smp_q(smp_q),
        .dac_clk(dac_clk), .dac_data(dac_data), .dac_sel_n(dac_sel_n),
        .dac_pd(dac_pd), .dac_en(dac_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance to the next falling system edge and update edge/stability tracking.
    task automatic step();
        @(negedge clk);
        rose = (!clk_prev && dac_clk);
        fell = (clk_prev && !dac_clk);
        clk_prev = dac_clk;
        if (dac_data != bus_prev) age = 0; else age++;
        bus_prev = dac_data;
    endtask

    task automatic wait_rise();
        step();
        while (!rose) step();
    endtask

    task automatic wait_fall();
        step();
        while (!fell) step();
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        step();
        while (!smp_ready) begin step(); n++; end
    endtask

    task automatic check_reset_state(input string tag);
        check(dac_pd == 1'b1,    tag, int'(dac_pd), 1);
        check(dac_en == 1'b0,    tag, int'(dac_en), 0);
        check(dac_sel_n == 1'b1, tag, int'(dac_sel_n), 1);
        check(dac_data == '0,    tag, int'(dac_data), 0);
        check(smp_ready == 1'b0, tag, int'(smp_ready), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n, hi, sel_lead;
        logic [W-1:0] exp_i, exp_q;
        bit ok_hold, ok_sel;

        repeat (4) step();
        check_reset_state("R1 reset");
        rst_n = 1'b1;

        // R2: clock period and high time
        wait_rise();
        n = 0; hi = 1;
        forever begin
            step(); n++;
            if (rose) break;
            if (dac_clk) hi++;
        end
        check(n == DIV,   "R2 period", n, DIV);
        check(hi == HALF, "R2 high time", hi, HALF);

        // R3: mode encodings, one cycle after request
        mode_req = 2'b01; step();
        check(!dac_pd && !dac_en, "R3 standby", {dac_pd, dac_en}, 0);
        mode_req = 2'b11; step();
        check(dac_pd && !dac_en, "R3 reserved=shutdown", {dac_pd, dac_en}, 2);
        mode_req = 2'b00; step();
        check(dac_pd && !dac_en, "R3 shutdown", {dac_pd, dac_en}, 2);
        mode_req = 2'b10; step();
        check(!dac_pd && dac_en, "R3 run", {dac_pd, dac_en}, 1);

        // R4: wake-up holdoff, select stays high meanwhile
        n = 0; ok_sel = 1'b1;
        while (!smp_ready) begin
            if (!dac_sel_n) ok_sel = 1'b0;
            step(); n++;
        end
        check(n >= WAKE, "R4 wake holdoff", n, WAKE);
        check(n < WAKE + DIV + 1, "R4 wake bound", n, WAKE + DIV);
        check(ok_sel, "R4 select high during wake", 0, 1);

        // Vector table: R6, R7, R8, R9
        exp_i = '0; exp_q = '0;
        for (int v = 0; v < NVEC; v++) begin
            if (v != 0) wait_ready(n);
            smp_valid = VEC[v][20];
            smp_i = VEC[v][19:10];
            smp_q = VEC[v][9:0];
            if (VEC[v][20]) begin exp_i = VEC[v][19:10]; exp_q = VEC[v][9:0]; end
            step();
            smp_valid = 1'b0;
            smp_i = ~smp_i;
            smp_q = ~smp_q;
            if (v == 0) begin
                check(!dac_sel_n, "R9 select low with first I", int'(dac_sel_n), 0);
                sel_lead = 0;
                step(); sel_lead++;
                while (!rose) begin step(); sel_lead++; end
                check(sel_lead >= CSLEAD, "R9 select lead", sel_lead, CSLEAD);
            end else begin
                wait_rise();
            end
            check(dac_data == exp_i, VEC[v][20] ? "R6 I at rise" : "R8 repeat I",
                  int'(dac_data), int'(exp_i));
            check(age >= SETUP, "R7 setup before rise", age, SETUP);
            step();
            ok_hold = (dac_data == exp_i);
            check(ok_hold, "R7 hold after rise", int'(dac_data), int'(exp_i));
            wait_fall();
            check(dac_data == exp_q, VEC[v][20] ? "R6 Q at fall" : "R8 repeat Q",
                  int'(dac_data), int'(exp_q));
            check(age >= SETUP, "R7 setup before fall", age, SETUP);
        end

        // R5: one ready per converter period
        n = 0;
        for (int k = 0; k < 3 * DIV; k++) begin
            step();
            if (smp_ready) n++;
        end
        check(n == 3, "R5 ready per period", n, 3);

        // R10: leaving run
        wait_ready(n);
        mode_req = 2'b01;
        step();
        check(!smp_ready, "R10 ready drops", int'(smp_ready), 0);
        step();
        check(dac_sel_n && dac_data == '0, "R10 deselect and park",
              {dac_sel_n, dac_data}, {1'b1, 10'h000});
        check(!dac_en && !dac_pd, "R10 standby lines", {dac_pd, dac_en}, 0);

        // R4 again: a second run request waits the full interval
        mode_req = 2'b10; step();
        n = 0;
        while (!smp_ready) begin step(); n++; end
        check(n >= WAKE, "R4 rewake holdoff", n, WAKE);

        // R1: reset while streaming
        rst_n = 1'b0; step(); step();
        check_reset_state("R1 mid-stream reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule